// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control unit of a small microcoded accumulator machine. A 4-bit microprogram counter selects one of sixteen microinstructions from a fixed, built-in microcode store. Each microinstruction word carries three fields. The first is a set of fifteen datapath strobes. The second is a four-bit next-address mode. The third is a pair of candidate next microaddresses.

The next-address unit chooses the following microaddress from the mode field and from several inputs: the memory handshake pins, the interrupt request, the interrupt-acknowledge flag, the accumulator zero flag and the three-bit opcode of the fetched instruction. The mode field selects one of four behaviours:

- a wait/interrupt step, which can hold in place;
- an opcode dispatch to opcode plus four;
- a two-way branch on the zero flag;
- a plain jump.

The datapath registers, the ALU and memory sit outside the block. The zero flag and the opcode arrive as plain inputs, and the decoded strobes leave as one vector.

Every machine instruction starts and ends at microaddress 0, and each instruction takes its own fixed number of cycles. A boundary flag marks each cycle in which the counter is at 0. Cycle counts per instruction can therefore be measured at the ports.

Top module: `microSequencer`

## Requirements
- R1: A synchronous `rst` high at a rising edge sets the microaddress `upc` to 0, and `instrStart` is then high.
- R2: The `strobes` bit order, from bit 14 down to bit 0, is: memory write, memory read, address-register write, PC write, PC read, accumulator write, accumulator read, IR write, IR read, return-register write, return-register read, operand-register write, ALU select 0, ALU select 1, buffer read. `memReq` is high exactly when bit 14 or bit 13 is high.
- R3: While `upc` is 0, `strobes` equals 15'h1400, so only PC read and address-register write are high.
- R4: At microaddress 0 with `idle` low and `dack` high, the counter stays at 0 regardless of `ireq` and `iack`.
- R5: At microaddress 0 when not holding, the next microaddress is 1 if `ireq` is high and `iack` is low. It is 2 in every other case.
- R6: From microaddress 3 the next microaddress is `opcode` + 4.
- R7: From microaddress 4 the next microaddress is 5 when `zeroFlag` is high and 11 when it is low.
- R8: With no interrupt taken, opcode 2 visits microaddresses 0, 2, 3, 6, 13, 15, 11, 12 and then returns to 0.
- R9: Cycles from one visit of microaddress 0 to the next, with `idle` and `dack` high:
  - interrupt entry: 3;
  - opcode 0: 5 if `zeroFlag` is high, otherwise 6;
  - opcode 1: 4;
  - opcodes 2 and 3: 8;
  - opcodes 4 and 5: 6;
  - opcode 6: 4;
  - opcode 7: 5.
- R10: `instrStart` is high exactly when `upc` is 0.
- R11: In every cycle, at most one of the bus read strobes (bits 13, 10, 8, 6, 4, 0) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| idle | input | 1 | Memory handshake: memory idle |
| dack | input | 1 | Memory handshake: data acknowledge |
| ireq | input | 1 | Interrupt request |
| iack | input | 1 | Interrupt-acknowledge flag from the datapath |
| zeroFlag | input | 1 | Accumulator is zero |
| opcode | input | 3 | Opcode field of the instruction register |
| strobes | output | 15 | Decoded datapath strobes (order in R2) |
| memReq | output | 1 | Memory request: read or write strobe active |
| upc | output | 4 | Current microprogram counter |
| instrStart | output | 1 | Instruction boundary: counter at 0 |

## Verification
The bench targets the priority at microaddress 0, where the handshake hold must override a pending interrupt and a set `iack` must mask the interrupt. A design that ordered these tests wrongly would leave the wait early or take an interrupt during a bus stall. It runs all eight opcodes, and opcode 0 with both values of `zeroFlag`, against the cycle-count table, so a wrong dispatch offset or an inverted zero branch shows up as a length mismatch. It also walks the exact microaddress path of opcode 2. Finally, it applies a reset in the middle of an instruction, which catches a counter that only clears at a boundary.

// File: rtl/microSeqPkg.sv
package microSeqPkg;
  localparam int UPC_W  = 4;
  localparam int CTL_W  = 15;
  localparam int MODE_W = 4;
  localparam int ROM_DEPTH = 1 << UPC_W;

  // Strobe bundle; field order matches the bit order of the control field.
  typedef struct packed {
    logic memWr;
    logic memRd;
    logic marWr;
    logic pcWr;
    logic pcRd;
    logic accWr;
    logic accRd;
    logic irWr;
    logic irRd;
    logic rtnWr;
    logic rtnRd;
    logic argWr;
    logic aluSel0;
    logic aluSel1;
    logic bufRd;
  } strobeT;

  // One microinstruction: control field, mode {f0,f1,f2,f3}, two targets.
  typedef struct packed {
    logic [CTL_W-1:0]  ctl;
    logic [MODE_W-1:0] mode;
    logic [UPC_W-1:0]  tgtA;
    logic [UPC_W-1:0]  tgtB;
  } uWordT;

  typedef enum logic [1:0] {
    NA_JUMP,
    NA_WAIT_IRQ,
    NA_DISPATCH,
    NA_ZERO
  } naKindT;

  localparam logic [MODE_W-1:0] MODE_WAIT_IRQ = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_DISPATCH = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_ZERO     = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_JUMP     = 4'b0000;
endpackage

// File: rtl/microRom.sv
module microRom
  import microSeqPkg::*;
(
  input  logic [UPC_W-1:0] addr,
  output uWordT            word
);
  function automatic uWordT mk(input logic [CTL_W-1:0] c, input logic [MODE_W-1:0] m,
                               input logic [UPC_W-1:0] a, input logic [UPC_W-1:0] b);
    uWordT w;
    w.ctl  = c;
    w.mode = m;
    w.tgtA = a;
    w.tgtB = b;
    return w;
  endfunction

  always_comb begin
    unique case (addr)
      4'd0:  word = mk(15'h1400, MODE_WAIT_IRQ, 4'd1,  4'd2);  // pc -> mar, wait/irq
      4'd1:  word = mk(15'h0420, MODE_JUMP,     4'd5,  4'd0);  // pc -> rtn (irq entry)
      4'd2:  word = mk(15'h2080, MODE_JUMP,     4'd3,  4'd0);  // mem -> ir
      4'd3:  word = mk(15'h1040, MODE_DISPATCH, 4'd0,  4'd0);  // ir -> mar, dispatch
      4'd4:  word = mk(15'h0000, MODE_ZERO,     4'd5,  4'd11); // zero test
      4'd5:  word = mk(15'h0840, MODE_JUMP,     4'd0,  4'd0);  // ir -> pc
      4'd6:  word = mk(15'h0108, MODE_JUMP,     4'd13, 4'd0);  // acc -> arg (add)
      4'd7:  word = mk(15'h0108, MODE_JUMP,     4'd14, 4'd0);  // acc -> arg (sub)
      4'd8:  word = mk(15'h2200, MODE_JUMP,     4'd11, 4'd0);  // mem -> acc
      4'd9:  word = mk(15'h4100, MODE_JUMP,     4'd11, 4'd0);  // acc -> mem
      4'd10: word = mk(15'h0810, MODE_JUMP,     4'd0,  4'd0);  // rtn -> pc
      4'd11: word = mk(15'h0406, MODE_JUMP,     4'd12, 4'd0);  // pc + 1 -> buf
      4'd12: word = mk(15'h0801, MODE_JUMP,     4'd0,  4'd0);  // buf -> pc
      4'd13: word = mk(15'h2004, MODE_JUMP,     4'd15, 4'd0);  // arg + mem -> buf
      4'd14: word = mk(15'h2002, MODE_JUMP,     4'd15, 4'd0);  // arg - mem -> buf
      4'd15: word = mk(15'h0201, MODE_JUMP,     4'd11, 4'd0);  // buf -> acc
    endcase
  end
endmodule

// File: rtl/nextAddrUnit.sv
module nextAddrUnit
  import microSeqPkg::*;
#(
  parameter int OPC_W    = 3,
  parameter int DISP_OFS = 4
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [UPC_W-1:0]  tgtA,
  input  logic [UPC_W-1:0]  tgtB,
  input  logic [UPC_W-1:0]  curUpc,
  input  logic              idle,
  input  logic              dack,
  input  logic              ireq,
  input  logic              iack,
  input  logic              zeroFlag,
  input  logic [OPC_W-1:0]  opcode,
  output logic [UPC_W-1:0]  nxt
);
  naKindT kind;

  always_comb begin
    unique case (mode)
      MODE_WAIT_IRQ: kind = NA_WAIT_IRQ;
      MODE_DISPATCH: kind = NA_DISPATCH;
      MODE_ZERO:     kind = NA_ZERO;
      default:       kind = NA_JUMP;   // any other coding is a plain jump
    endcase
  end

  always_comb begin
    unique case (kind)
      NA_WAIT_IRQ: begin
        if (!idle && dack)       nxt = curUpc;
        else if (ireq && !iack)  nxt = tgtA;
        else                     nxt = tgtB;
      end
      NA_DISPATCH: nxt = UPC_W'(opcode) + UPC_W'(DISP_OFS);
      NA_ZERO:     nxt = zeroFlag ? tgtA : tgtB;
      default:     nxt = tgtA;
    endcase
  end
endmodule

// File: rtl/strobeDecode.sv
module strobeDecode
  import microSeqPkg::*;
(
  input  logic [CTL_W-1:0] ctl,
  output strobeT           stb,
  output logic             memReq
);
  always_comb begin
    stb    = strobeT'(ctl);
    memReq = stb.memWr | stb.memRd;
  end
endmodule

// File: rtl/microSequencer.sv
module microSequencer
  import microSeqPkg::*;
#(
  parameter int OPC_W    = 3,
  parameter int DISP_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              dack,
  input  logic              ireq,
  input  logic              iack,
  input  logic              zeroFlag,
  input  logic [OPC_W-1:0]  opcode,
  output logic [CTL_W-1:0]  strobes,
  output logic              memReq,
  output logic [UPC_W-1:0]  upc,
  output logic              instrStart
);
  logic [UPC_W-1:0] upcQ;
  logic [UPC_W-1:0] upcNxt;
  uWordT            uWord;
  strobeT           stb;

  microRom uRom (
    .addr (upcQ),
    .word (uWord)
  );

  nextAddrUnit #(.OPC_W(OPC_W), .DISP_OFS(DISP_OFS)) uNext (
    .mode     (uWord.mode),
    .tgtA     (uWord.tgtA),
    .tgtB     (uWord.tgtB),
    .curUpc   (upcQ),
    .idle     (idle),
    .dack     (dack),
    .ireq     (ireq),
    .iack     (iack),
    .zeroFlag (zeroFlag),
    .opcode   (opcode),
    .nxt      (upcNxt)
  );

  strobeDecode uDec (
    .ctl    (uWord.ctl),
    .stb    (stb),
    .memReq (memReq)
  );

  always_ff @(posedge clk) begin
    if (rst) upcQ <= '0;
    else     upcQ <= upcNxt;
  end

  assign strobes    = stb;
  assign upc        = upcQ;
  assign instrStart = (upcQ == '0);

  // R1: reset returns the counter to 0
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (upcQ == '0));

  // R4: handshake hold at microaddress 0
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (upcQ == '0 && !idle && dack) |=> (upcQ == '0));

  // R5: interrupt branch and fetch path out of microaddress 0
  a_r5_irq_branch: assert property (@(posedge clk) disable iff (rst)
    (upcQ == '0 && (idle || !dack) && ireq && !iack) |=> (upcQ == UPC_W'(1)));
  a_r5_fetch_branch: assert property (@(posedge clk) disable iff (rst)
    (upcQ == '0 && (idle || !dack) && !(ireq && !iack)) |=> (upcQ == UPC_W'(2)));

  // R6: opcode dispatch
  a_r6_dispatch: assert property (@(posedge clk) disable iff (rst)
    (upcQ == UPC_W'(3)) |=> (upcQ == UPC_W'($past(opcode)) + UPC_W'(DISP_OFS)));

  // R7: zero-flag branch
  a_r7_zero_branch: assert property (@(posedge clk) disable iff (rst)
    (upcQ == UPC_W'(4)) |=> (upcQ == ($past(zeroFlag) ? UPC_W'(5) : UPC_W'(11))));

  // R11: single bus reader
  a_r11_one_reader: assert property (@(posedge clk) disable iff (rst)
    $countones({stb.memRd, stb.pcRd, stb.accRd, stb.irRd, stb.rtnRd, stb.bufRd}) <= 1);
endmodule

// File: tb/sim_microSequencer.sv
`timescale 1ns/1ps
module sim_microSequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idle = 1'b1;
  logic        dack = 1'b1;
  logic        ireq = 1'b0;
  logic        iack = 1'b0;
  logic        zeroFlag = 1'b0;
  logic [2:0]  opcode = 3'd0;
  logic [14:0] strobes;
  logic        memReq;
  logic [3:0]  upc;
  logic        instrStart;

  int nChecks = 0;
  int nFails  = 0;
  int lenQ[$];
  bit monOn = 1'b1;
  bit started = 1'b0;
  bit prevZero = 1'b0;
  int cycCnt = 0;

  always #4 clk = ~clk;

  microSequencer u0 (
    .clk(clk), .rst(rst), .idle(idle), .dack(dack), .ireq(ireq), .iack(iack),
    .zeroFlag(zeroFlag), .opcode(opcode), .strobes(strobes), .memReq(memReq),
    .upc(upc), .instrStart(instrStart)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lenOf(input int o, input bit z, input bit irq);
    if (irq) return 3;
    case (o)
      0: return z ? 5 : 6;
      1: return 4;
      2, 3: return 8;
      4, 5: return 6;
      6: return 4;
      default: return 5;
    endcase
  endfunction

  // Monitor: per-cycle port checks and instruction length scoreboard.
  always @(posedge clk) begin
    #2;
    chk(instrStart == (upc == 4'd0), "R10 boundary flag", int'(instrStart), int'(upc == 4'd0));
    chk(memReq == (strobes[14] | strobes[13]), "R2 memReq", int'(memReq), int'(strobes[14] | strobes[13]));
    chk($countones({strobes[13], strobes[10], strobes[8], strobes[6], strobes[4], strobes[0]}) <= 1,
        "R11 one reader", $countones({strobes[13], strobes[10], strobes[8], strobes[6], strobes[4], strobes[0]}), 1);
    if (upc == 4'd0) chk(strobes == 15'h1400, "R3 strobes at 0", int'(strobes), 'h1400);
    if (!monOn) begin
      started = 1'b0;
      prevZero = instrStart;
    end else if (rst) begin
      started = 1'b1;
      cycCnt = 1;
      prevZero = 1'b1;
    end else begin
      if (instrStart && !prevZero) begin
        if (started) begin
          if (lenQ.size() == 0) chk(1'b0, "R9 no expected length", cycCnt, -1);
          else begin
            int e;
            e = lenQ.pop_front();
            chk(cycCnt == e, "R9 instruction length", cycCnt, e);
          end
        end
        started = 1'b1;
        cycCnt = 1;
      end else begin
        cycCnt++;
      end
      prevZero = instrStart;
    end
  end

  // Driver: runs one instruction from microaddress 0 back to 0.
  task automatic runInstr(input int o, input bit z, input bit irq);
    logic [3:0] seq[16];
    int n;
    opcode = 3'(o);
    zeroFlag = z;
    ireq = irq;
    lenQ.push_back(lenOf(o, z, irq));
    n = 0;
    seq[0] = upc;
    do begin
      @(negedge clk);
      n++;
      seq[n] = upc;
      ireq = 1'b0;
    end while (upc != 4'd0 && n < 15);
    chk(seq[1] == (irq ? 4'd1 : 4'd2), "R5 branch from 0", int'(seq[1]), irq ? 1 : 2);
    if (!irq) chk(seq[3] == 4'(o + 4), "R6 dispatch", int'(seq[3]), o + 4);
    if (!irq && o == 0) chk(seq[4] == (z ? 4'd5 : 4'd11), "R7 zero branch", int'(seq[4]), z ? 5 : 11);
    if (!irq && o == 2) begin
      int addPath[9] = '{0, 2, 3, 6, 13, 15, 11, 12, 0};
      for (int k = 0; k < 9; k++) chk(int'(seq[k]) == addPath[k], "R8 add path", int'(seq[k]), addPath[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(upc == 4'd0, "R1 reset upc", int'(upc), 0);
    chk(instrStart == 1'b1, "R1 reset boundary", int'(instrStart), 1);
    rst = 1'b0;
    for (int o = 0; o < 8; o++) runInstr(o, 1'b0, 1'b0);
    runInstr(0, 1'b1, 1'b0);
    runInstr(3, 1'b1, 1'b1);
    runInstr(2, 1'b1, 1'b0);
    runInstr(5, 1'b0, 1'b1);
    runInstr(6, 1'b0, 1'b0);
    chk(lenQ.size() == 0, "R9 all lengths compared", lenQ.size(), 0);

    // Priority tests at microaddress 0
    monOn = 1'b0;
    idle = 1'b0; dack = 1'b1; ireq = 1'b1; iack = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(upc == 4'd0, "R4 hold despite ireq", int'(upc), 0);
    end
    idle = 1'b1;
    @(negedge clk);
    chk(upc == 4'd1, "R5 irq after hold", int'(upc), 1);
    ireq = 1'b0;
    while (upc != 4'd0) @(negedge clk);
    idle = 1'b0; dack = 1'b0; ireq = 1'b1; iack = 1'b1; opcode = 3'd7;
    @(negedge clk);
    chk(upc == 4'd2, "R5 iack masks irq", int'(upc), 2);
    ireq = 1'b0; iack = 1'b0; idle = 1'b1; dack = 1'b1;
    while (upc != 4'd0) @(negedge clk);

    // Reset in the middle of an instruction
    opcode = 3'd2;
    repeat (4) @(negedge clk);
    chk(upc == 4'd13, "R8 mid add", int'(upc), 13);
    rst = 1'b1;
    @(negedge clk);
    chk(upc == 4'd0, "R1 mid-run reset", int'(upc), 0);
    chk(instrStart == 1'b1, "R1 mid-run boundary", int'(instrStart), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(upc == 4'd2, "R5 fetch after reset", int'(upc), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule